// File: doc/BRIEF.md
# Machine-Mode Control and Status Register File

This block holds the control and status registers of a 32-bit core that runs in machine and supervisor modes. It has one combinational read port and one write port, both addressed by a 12-bit register number. Behind the decoder are the machine trap registers, the supervisor trap registers, a read-only ISA descriptor, and two 64-bit event counters. The first counter advances on every clock. The second advances on each pulse of a retire input. Each counter is read as two 32-bit halves.

The surrounding pipeline owns trap sequencing, privilege checks and the choice of when to retire an instruction. This block provides only the storage, the address decode, the reset values and the counter views. A write lands at the next rising edge. A read returns whatever the register holds in the current cycle.

Top module: `mcsr_bank`

## Requirements
- R1: The machine registers at 0x300, 0x302, 0x303, 0x304, 0x305, 0x306, 0x310, 0x340, 0x341, 0x342, 0x343 and 0x344 are each 32 bits wide and read back the last value written to them.
- R2: The supervisor registers at 0x105, 0x140, 0x141, 0x142, 0x143 and 0x144 are each 32 bits wide and read back the last value written to them.
- R3: Address 0x301 always reads 0x40001105: bit 30 for the 32-bit width, plus bits 0, 2, 8 and 12. Writes to 0x301 have no effect.
- R4: Reset is synchronous and active high. After reset, 0x300 reads 0x40000000, and every other stored register and both counters read zero.
- R5: The cycle counter is 64 bits wide. It adds one on every clock edge outside reset and wraps from all ones to zero.
- R6: Addresses 0xB00 and 0xC00 read bits [31:0] of the cycle counter. Addresses 0xB80 and 0xC80 read bits [63:32].
- R7: Addresses 0xC01 and 0xC81 read the low and high halves of the same cycle counter.
- R8: A write to 0xB00 or 0xB80 loads that half of the cycle counter, while the other half takes its incremented value. A write to any 0xCxx counter view has no effect.
- R9: The retire counter is 64 bits wide and adds one on each clock edge where `retire` is high. It is read low/high at 0xB02/0xB82 and at 0xC02/0xC82. Writes to 0xB02 or 0xB82 load that half.
- R10: A write takes effect at the next rising edge. A read of the same address in the write cycle returns the old value.
- R11: Every address not listed above reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 12 | Read register number |
| rd_data | output | 32 | Combinational read data |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write register number |
| wr_data | input | 32 | Write data |
| retire | input | 1 | One pulse per retired instruction |

## Verification
The bound checker checks the following on every cycle:
- the fixed ISA value;
- the one-step advance of the cycle counter;
- the retire count following its input;
- the low-half load;
- the alias of the time view;
- read-after-write on stored registers;
- zero reads from unmapped addresses;
- the status value just after reset.

Some behaviour only the bench scenarios can show. The bench sweeps all 4096 addresses three times: after reset, while writing every address, and again after the writes. This shows that writes to read-only and unmapped addresses change nothing anywhere. A directed sequence shows the 64-bit wrap across both halves.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

   localparam int unsigned CSR_AW  = 12;
   localparam int unsigned N_STORE = 18;

   typedef logic [CSR_AW-1:0] csr_addr_t;

   localparam csr_addr_t ADR_STATUS  = 12'h300;
   localparam csr_addr_t ADR_ISA     = 12'h301;
   localparam csr_addr_t ADR_MCYC_LO = 12'hB00;
   localparam csr_addr_t ADR_MCYC_HI = 12'hB80;
   localparam csr_addr_t ADR_UCYC_LO = 12'hC00;
   localparam csr_addr_t ADR_UCYC_HI = 12'hC80;
   localparam csr_addr_t ADR_TIME_LO = 12'hC01;
   localparam csr_addr_t ADR_TIME_HI = 12'hC81;
   localparam csr_addr_t ADR_MRET_LO = 12'hB02;
   localparam csr_addr_t ADR_MRET_HI = 12'hB82;
   localparam csr_addr_t ADR_URET_LO = 12'hC02;
   localparam csr_addr_t ADR_URET_HI = 12'hC82;

   typedef enum logic [2:0] {
      VIEW_NONE,
      VIEW_ISA,
      VIEW_CYC_LO,
      VIEW_CYC_HI,
      VIEW_RET_LO,
      VIEW_RET_HI
   } view_e;

   // Register number of each plain storage slot.
   function automatic csr_addr_t store_addr(input int unsigned idx);
      case (idx)
         0:       return ADR_STATUS;
         1:       return 12'h302;
         2:       return 12'h303;
         3:       return 12'h304;
         4:       return 12'h305;
         5:       return 12'h306;
         6:       return 12'h310;
         7:       return 12'h340;
         8:       return 12'h341;
         9:       return 12'h342;
         10:      return 12'h343;
         11:      return 12'h344;
         12:      return 12'h105;
         13:      return 12'h140;
         14:      return 12'h141;
         15:      return 12'h142;
         16:      return 12'h143;
         default: return 12'h144;
      endcase
   endfunction

   // Which computed or constant view an address selects.
   function automatic view_e counter_view(input csr_addr_t a);
      case (a)
         ADR_ISA:                                return VIEW_ISA;
         ADR_MCYC_LO, ADR_UCYC_LO, ADR_TIME_LO: return VIEW_CYC_LO;
         ADR_MCYC_HI, ADR_UCYC_HI, ADR_TIME_HI: return VIEW_CYC_HI;
         ADR_MRET_LO, ADR_URET_LO:              return VIEW_RET_LO;
         ADR_MRET_HI, ADR_URET_HI:              return VIEW_RET_HI;
         default:                                return VIEW_NONE;
      endcase
   endfunction

   function automatic logic is_store(input csr_addr_t a);
      logic hit;
      hit = 1'b0;
      for (int unsigned k = 0; k < N_STORE; k++) begin
         if (store_addr(k) == a) hit = 1'b1;
      end
      return hit;
   endfunction

   function automatic logic is_mapped(input csr_addr_t a);
      return is_store(a) || (counter_view(a) != VIEW_NONE);
   endfunction

endpackage

// File: rtl/mcsr_store.sv
module mcsr_store
   import mcsr_pkg::*;
#(
   parameter int unsigned     XLEN        = 32,
   parameter logic [XLEN-1:0] STATUS_INIT = 32'h4000_0000
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  csr_addr_t       wr_addr,
   input  logic [XLEN-1:0] wr_data,
   input  csr_addr_t       rd_addr,
   output logic [XLEN-1:0] rd_val
);

   logic [XLEN-1:0] masked [N_STORE];

   for (genvar i = 0; i < N_STORE; i++) begin : g_ent
      localparam csr_addr_t MY_ADDR = store_addr(i);
      logic [XLEN-1:0] q;
      logic            wr_hit;

      assign wr_hit = wr_en && (wr_addr == MY_ADDR);

      if (MY_ADDR == ADR_STATUS) begin : g_status
         always_ff @(posedge clk) begin
            if (rst)         q <= STATUS_INIT;
            else if (wr_hit) q <= wr_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (rst)         q <= '0;
            else if (wr_hit) q <= wr_data;
         end
      end

      assign masked[i] = (rd_addr == MY_ADDR) ? q : '0;
   end

   always_comb begin
      rd_val = '0;
      for (int unsigned k = 0; k < N_STORE; k++) begin
         rd_val = rd_val | masked[k];
      end
   end

endmodule

// File: rtl/mcsr_wcounter.sv
module mcsr_wcounter #(
   parameter int unsigned HALF_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                inc,
   input  logic                ld_lo,
   input  logic                ld_hi,
   input  logic [HALF_W-1:0]   ld_data,
   output logic [2*HALF_W-1:0] value
);

   localparam int unsigned FULL_W = 2 * HALF_W;

   if (HALF_W == 0) begin : g_bad_width
      $error("mcsr_wcounter: HALF_W must be nonzero");
   end

   logic [FULL_W-1:0] cnt;
   logic [FULL_W-1:0] stepped;

   assign stepped = cnt + FULL_W'(inc);

   always_ff @(posedge clk) begin
      if (rst)        cnt <= '0;
      else if (ld_lo) cnt <= {stepped[FULL_W-1:HALF_W], ld_data};
      else if (ld_hi) cnt <= {ld_data, stepped[HALF_W-1:0]};
      else            cnt <= stepped;
   end

   assign value = cnt;

endmodule

// File: rtl/mcsr_bank.sv
module mcsr_bank
   import mcsr_pkg::*;
#(
   parameter int unsigned     XLEN        = 32,
   parameter logic [XLEN-1:0] ISA_VALUE   = 32'h4000_1105,
   parameter logic [XLEN-1:0] STATUS_INIT = 32'h4000_0000
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [11:0]     rd_addr,
   output logic [XLEN-1:0] rd_data,
   input  logic            wr_en,
   input  logic [11:0]     wr_addr,
   input  logic [XLEN-1:0] wr_data,
   input  logic            retire
);

   localparam int unsigned CNT_W = 2 * XLEN;

   if (XLEN != 32) begin : g_bad_xlen
      $error("mcsr_bank: only a 32-bit register width is supported");
   end
   if (ISA_VALUE[XLEN-1:XLEN-2] != 2'b01) begin : g_bad_isa
      $error("mcsr_bank: ISA width field must encode 32 bits");
   end

   logic [XLEN-1:0]  st_val;
   logic [CNT_W-1:0] cyc_cnt;
   logic [CNT_W-1:0] ret_cnt;

   mcsr_store #(
      .XLEN        (XLEN),
      .STATUS_INIT (STATUS_INIT)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_val  (st_val)
   );

   mcsr_wcounter #(.HALF_W(XLEN)) u_cycle (
      .clk     (clk),
      .rst     (rst),
      .inc     (1'b1),
      .ld_lo   (wr_en && (wr_addr == ADR_MCYC_LO)),
      .ld_hi   (wr_en && (wr_addr == ADR_MCYC_HI)),
      .ld_data (wr_data),
      .value   (cyc_cnt)
   );

   mcsr_wcounter #(.HALF_W(XLEN)) u_retire (
      .clk     (clk),
      .rst     (rst),
      .inc     (retire),
      .ld_lo   (wr_en && (wr_addr == ADR_MRET_LO)),
      .ld_hi   (wr_en && (wr_addr == ADR_MRET_HI)),
      .ld_data (wr_data),
      .value   (ret_cnt)
   );

   always_comb begin
      case (counter_view(rd_addr))
         VIEW_ISA:    rd_data = ISA_VALUE;
         VIEW_CYC_LO: rd_data = cyc_cnt[XLEN-1:0];
         VIEW_CYC_HI: rd_data = cyc_cnt[CNT_W-1:XLEN];
         VIEW_RET_LO: rd_data = ret_cnt[XLEN-1:0];
         VIEW_RET_HI: rd_data = ret_cnt[CNT_W-1:XLEN];
         default:     rd_data = st_val;
      endcase
   end

endmodule

// File: rtl/mcsr_bank_chk.sv
module mcsr_bank_chk
   import mcsr_pkg::*;
#(
   parameter int unsigned     XLEN        = 32,
   parameter logic [XLEN-1:0] ISA_VALUE   = 32'h4000_1105,
   parameter logic [XLEN-1:0] STATUS_INIT = 32'h4000_0000
) (
   input logic              clk,
   input logic              rst,
   input logic [11:0]       rd_addr,
   input logic [XLEN-1:0]   rd_data,
   input logic              wr_en,
   input logic [11:0]       wr_addr,
   input logic [XLEN-1:0]   wr_data,
   input logic              retire,
   input logic [2*XLEN-1:0] cyc_q,
   input logic [2*XLEN-1:0] ret_q
);

   logic cyc_ld;
   logic ret_ld;
   assign cyc_ld = wr_en && ((wr_addr == ADR_MCYC_LO) || (wr_addr == ADR_MCYC_HI));
   assign ret_ld = wr_en && ((wr_addr == ADR_MRET_LO) || (wr_addr == ADR_MRET_HI));

   p_isa_fixed_r3: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == ADR_ISA) |-> (rd_data == ISA_VALUE));

   p_status_init_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && (rd_addr == ADR_STATUS)) |-> (rd_data == STATUS_INIT));

   p_cycle_step_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(cyc_ld)) |-> (cyc_q == $past(cyc_q) + 1'b1));

   p_time_alias_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == ADR_TIME_HI) |-> (rd_data == cyc_q[2*XLEN-1:XLEN]));

   p_load_low_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en && (wr_addr == ADR_MCYC_LO)))
      |-> (cyc_q[XLEN-1:0] == $past(wr_data)));

   p_retire_count_r9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(ret_ld))
      |-> (ret_q == $past(ret_q) + (2*XLEN)'($past(retire))));

   p_write_visible_r10: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && (rd_addr == $past(wr_addr)) && is_store(rd_addr))
      |-> (rd_data == $past(wr_data)));

   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
      !is_mapped(rd_addr) |-> (rd_data == '0));

endmodule

bind mcsr_bank mcsr_bank_chk #(
   .XLEN        (XLEN),
   .ISA_VALUE   (ISA_VALUE),
   .STATUS_INIT (STATUS_INIT)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .rd_addr (rd_addr),
   .rd_data (rd_data),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .retire  (retire),
   .cyc_q   (cyc_cnt),
   .ret_q   (ret_cnt)
);

// File: tb/mcsr_bank_test.sv
module mcsr_bank_test;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst;
   logic [11:0] rd_addr;
   logic [31:0] rd_data;
   logic        wr_en;
   logic [11:0] wr_addr;
   logic [31:0] wr_data;
   logic        retire;

   always #2.5 clk = ~clk;

   mcsr_bank uut (
      .clk     (clk),
      .rst     (rst),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .retire  (retire)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   localparam logic [11:0] ST_LIST [18] = '{
      12'h300, 12'h302, 12'h303, 12'h304, 12'h305, 12'h306, 12'h310,
      12'h340, 12'h341, 12'h342, 12'h343, 12'h344,
      12'h105, 12'h140, 12'h141, 12'h142, 12'h143, 12'h144};

   logic [63:0] m_cyc;
   logic [63:0] m_ret;
   logic [31:0] m_st [18];

   function automatic int st_idx(input logic [11:0] a);
      for (int k = 0; k < 18; k++) if (ST_LIST[k] == a) return k;
      return -1;
   endfunction

   // Split counter rule from R5, R8, R9: loaded half takes the data, the other steps.
   function automatic logic [63:0] next_cnt(input logic [63:0] c, input logic inc,
                                            input logic lo, input logic hi,
                                            input logic [31:0] d);
      logic [63:0] s;
      s = c + {63'd0, inc};
      if (lo)      return {s[63:32], d};
      else if (hi) return {d, s[31:0]};
      return s;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cyc <= 64'd0;
         m_ret <= 64'd0;
         for (int k = 0; k < 18; k++) m_st[k] <= (k == 0) ? 32'h4000_0000 : 32'd0;
      end else begin
         m_cyc <= next_cnt(m_cyc, 1'b1, wr_en && wr_addr == 12'hB00,
                           wr_en && wr_addr == 12'hB80, wr_data);
         m_ret <= next_cnt(m_ret, retire, wr_en && wr_addr == 12'hB02,
                           wr_en && wr_addr == 12'hB82, wr_data);
         if (wr_en && st_idx(wr_addr) >= 0) m_st[st_idx(wr_addr)] <= wr_data;
      end
   end

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      case (a)
         12'h301:                   return 32'h4000_1105;
         12'hB00, 12'hC00, 12'hC01: return m_cyc[31:0];
         12'hB80, 12'hC80, 12'hC81: return m_cyc[63:32];
         12'hB02, 12'hC02:          return m_ret[31:0];
         12'hB82, 12'hC82:          return m_ret[63:32];
         default: begin
            if (st_idx(a) >= 0) return m_st[st_idx(a)];
            return 32'd0;
         end
      endcase
   endfunction

   function automatic string req_of(input logic [11:0] a);
      case (a)
         12'h301:                            return "R3";
         12'hB00, 12'hC00, 12'hB80, 12'hC80: return "R6/R8";
         12'hC01, 12'hC81:                   return "R7";
         12'hB02, 12'hC02, 12'hB82, 12'hC82: return "R9";
         default: begin
            if (st_idx(a) >= 12) return "R2";
            if (st_idx(a) >= 0)  return "R1";
            return "R11";
         end
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic check_read(input logic [11:0] a, input string tag);
      rd_addr = a;
      #0.5;
      check({tag, req_of(a)}, rd_data, exp_read(a));
   endtask

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; retire = 1'b0; rd_addr = '0;
      repeat (3) step();
      // R4: values held under reset
      rd_addr = 12'h300; #0.5; check("R4 status", rd_data, 32'h4000_0000);
      rd_addr = 12'hB00; #0.5; check("R4 cycle", rd_data, 32'd0);
      rst = 1'b0;
      rd_addr = 12'h340; #0.5; check("R4 scratch", rd_data, 32'd0);

      // R4/R11: sweep every address after reset
      for (int a = 0; a < 4096; a++) begin
         step();
         check_read(12'(a), "R4 ");
      end

      // R10: write every address; same-cycle read returns the old value
      for (int a = 0; a < 4096; a++) begin
         step();
         wr_en   = 1'b1;
         wr_addr = 12'(a);
         wr_data = {a[7:0], ~a[11:4], a[11:4], 8'h5A};
         retire  = a[0];
         check_read(12'(a), "R10 ");
      end
      step();
      wr_en = 1'b0;

      // R1 R2 R3 R8 R11: read back after the write sweep
      for (int a = 0; a < 4096; a++) begin
         step();
         retire = a[1] ^ a[3];
         check_read(12'(a), "");
      end
      step();
      retire = 1'b0;

      // R10: explicit read-old then read-new
      wr_en = 1'b1; wr_addr = 12'h340; wr_data = 32'hDEAD_BEEF; rd_addr = 12'h340;
      #0.5; check("R10 old", rd_data, 32'h0040_5A5A ^ 32'h0040_5A5A ^ exp_read(12'h340));
      step();
      wr_en = 1'b0;
      #0.5; check("R10 new", rd_data, 32'hDEAD_BEEF);

      // R5: 64-bit wrap of the cycle counter
      wr_en = 1'b1; wr_addr = 12'hB00; wr_data = 32'hFFFF_FFFC;
      step();
      wr_addr = 12'hB80; wr_data = 32'hFFFF_FFFF;
      step();
      wr_en = 1'b0;
      rd_addr = 12'hC00; #0.5; check("R5 low", rd_data, 32'hFFFF_FFFD);
      step();
      rd_addr = 12'hC01; #0.5; check("R5 low+1", rd_data, 32'hFFFF_FFFE);
      step();
      rd_addr = 12'hC81; #0.5; check("R5 high all ones", rd_data, 32'hFFFF_FFFF);
      step();
      rd_addr = 12'hC80; #0.5; check("R5 high wrapped", rd_data, 32'd0);
      step();
      rd_addr = 12'hB00; #0.5; check("R5 low after wrap", rd_data, 32'd1);

      // R9: retire pulses after a fresh reset
      rst = 1'b1;
      step();
      rst = 1'b0;
      rd_addr = 12'h300; #0.5; check("R4 status again", rd_data, 32'h4000_0000);
      retire = 1'b1;
      repeat (3) step();
      retire = 1'b0;
      repeat (2) step();
      rd_addr = 12'hC02; #0.5; check("R9 retire count", rd_data, 32'd3);
      rd_addr = 12'hB82; #0.5; check("R9 retire high", rd_data, 32'd0);

      finish_run();
   end

endmodule